// File: doc/BRIEF.md
# Width-Switchable Static RAM Core

This block is a clocked, synthesizable model of a static RAM whose data organization is chosen by a mode input. With the mode input high, it stores 16-bit words and has two byte-lane enables that mask the low and high halves of each access. With the mode input low, it stores 8-bit bytes. In byte mode an extra address input becomes the least-significant address bit, and only the low data lane is used. Both views share the same storage. Byte address {word, 0} is the low half of that word, and byte address {word, 1} is its high half.

Two chip enables of opposite polarity select the device. An active-low output enable and an active-low write enable choose the operation. The bidirectional data pins are replaced by a split bus: a data-in bus, a data-out bus, and a two-bit vector that says which output lanes would be driven. Writes commit on the rising clock edge. A read returns registered array data one clock after its address and controls are presented.

The storage depth is a parameter so that simulation can use a small array. The port address is always 17 bits wide. An address beyond the modelled depth is treated as a deselected access.

Top module: `sram_x16x8`

## Requirements
- R1: The device is selected only when `ce1N` is 0 and `ce2` is 1. Otherwise nothing is written, and on the next cycle `laneOe` is 2'b00.
- R2: With `wordMode`=1, `addr` selects one 16-bit word, and `byteAddr` has no effect on reads or writes.
- R3: With `wordMode`=0, the byte address is {`addr`,`byteAddr`}. A write stores `dataIn[7:0]`. A read drives only lane 0 (`laneOe`=2'b01), and `dataOut[15:8]` reads 0.
- R4: With `wordMode`=1 and both `lbN` and `ubN` high, the device acts as deselected: there is no write and no drive.
- R5: Output lanes are driven only after a selected cycle with `weN`=1 and `oeN`=0. A selected cycle with `oeN`=1 and `weN`=1 gives `laneOe`=2'b00.
- R6: In word mode, `lbN`=0 enables lane 0 (bits 7:0) and `ubN`=0 enables lane 1 (bits 15:8), for both reads and writes. `laneOe[0]` and `laneOe[1]` follow these enables. A masked lane keeps its stored byte on a write.
- R7: A selected cycle with `weN`=0 writes whatever the level of `oeN`. On the next cycle `laneOe` is 2'b00.
- R8: In byte mode, `lbN` and `ubN` have no effect.
- R9: Byte address {A,0} maps to bits 7:0 of word A, and {A,1} maps to bits 15:8 of word A.
- R10: Read data and `laneOe` appear on the cycle after the inputs are sampled. A write is visible to a read sampled on the next edge. Undriven lanes of `dataOut` read 0.
- R11: After reset, `laneOe` is 2'b00 and `dataOut` is 0 until the first read completes.
- R12: An `addr` at or above the modelled word depth (2^`DEPTH_W`) acts as deselected: there is no write and no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and read registers update on the rising edge |
| rstN | input | 1 | Active-low synchronous reset of the output registers |
| wordMode | input | 1 | 1 = 16-bit words, 0 = 8-bit bytes |
| addr | input | 17 | Word address |
| byteAddr | input | 1 | Low byte-address bit, used in byte mode only |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| lbN | input | 1 | Low byte-lane enable, active low (word mode) |
| ubN | input | 1 | High byte-lane enable, active low (word mode) |
| dataIn | input | 16 | Write data |
| dataOut | output | 16 | Read data; undriven lanes are 0 |
| laneOe | output | 2 | Per-lane output drive; bit 0 = bits 7:0, bit 1 = bits 15:8 |

## Verification
Full-word writes and reads with distinct patterns in each byte separate the two lanes. Masked writes followed by full reads show that a masked byte keeps its old value rather than being cleared or swapped. Word writes read back as bytes, and byte writes read back as words, which confirms the {A,0} = low and {A,1} = high mapping in both directions. Writes attempted while deselected, with both lanes masked, or at an out-of-range address are followed by reads that show the stored words unchanged. A write immediately followed by a read of the same word pins the one-cycle latency.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef struct packed {
    logic             rdEn;
    logic [LANES-1:0] wrLane;
    logic [LANES-1:0] driveLane;
    logic             byteMode;
    logic             selHi;
  } strobes_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DEPTH_W = 10
) (
  input  logic              wordMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byteAddr,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              oeN,
  input  logic              weN,
  input  logic              lbN,
  input  logic              ubN,
  output strobes_t          strobes
);
  localparam int HIGH_W = ADDR_W - DEPTH_W;

  logic chipOn;
  logic inRange;
  logic laneAny;
  logic selected;
  logic doWrite;
  logic doRead;

  generate
    if (HIGH_W > 0) begin : gRange
      assign inRange = (addr[ADDR_W-1:DEPTH_W] == '0);
    end else begin : gFull
      assign inRange = 1'b1;
    end
  endgenerate

  assign chipOn   = !ce1N && ce2;
  assign laneAny  = !wordMode || !(lbN && ubN);
  assign selected = chipOn && inRange && laneAny;
  assign doWrite  = selected && !weN;
  assign doRead   = selected && weN && !oeN;

  always_comb begin
    strobes          = '0;
    strobes.rdEn     = doRead;
    strobes.byteMode = !wordMode;
    strobes.selHi    = !wordMode && byteAddr;
    if (wordMode) begin
      strobes.wrLane    = {doWrite && !ubN, doWrite && !lbN};
      strobes.driveLane = {doRead && !ubN, doRead && !lbN};
    end else begin
      strobes.wrLane    = {doWrite && byteAddr, doWrite && !byteAddr};
      strobes.driveLane = {1'b0, doRead};
    end
  end
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int DEPTH_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DEPTH_W-1:0] wordIdx,
  input  logic [DATA_W-1:0]  dataIn,
  input  strobes_t           strobes,
  output logic [DATA_W-1:0]  dataOut,
  output logic [LANES-1:0]   laneOe
);
  localparam int DEPTH = 1 << DEPTH_W;

  logic [DATA_W-1:0] rdAll;
  logic [LANES-1:0]  driveQ;
  logic              byteModeQ;
  logic              selHiQ;

  generate
    for (genvar g = 0; g < LANES; g++) begin : gBank
      logic [LANE_W-1:0] bankMem [DEPTH];
      logic [LANE_W-1:0] wrByte;
      logic [LANE_W-1:0] rdQ;

      assign wrByte = strobes.byteMode ? dataIn[LANE_W-1:0]
                                       : dataIn[g*LANE_W +: LANE_W];

      always_ff @(posedge clk) begin
        if (strobes.wrLane[g]) bankMem[wordIdx] <= wrByte;
        if (strobes.rdEn)      rdQ <= bankMem[wordIdx];
      end

      assign rdAll[g*LANE_W +: LANE_W] = rdQ;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      driveQ    <= '0;
      byteModeQ <= 1'b0;
      selHiQ    <= 1'b0;
    end else begin
      driveQ    <= strobes.driveLane;
      byteModeQ <= strobes.byteMode;
      selHiQ    <= strobes.selHi;
    end
  end

  always_comb begin
    dataOut = '0;
    if (byteModeQ) begin
      if (driveQ[0])
        dataOut[LANE_W-1:0] = selHiQ ? rdAll[LANE_W +: LANE_W] : rdAll[LANE_W-1:0];
    end else begin
      for (int i = 0; i < LANES; i++)
        if (driveQ[i]) dataOut[i*LANE_W +: LANE_W] = rdAll[i*LANE_W +: LANE_W];
    end
  end

  assign laneOe = driveQ;

  // Byte mode never writes both banks at once (R3, R9)
  assert_byte_single_bank_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.byteMode |-> $onehot0(strobes.wrLane));

  // Reads and writes are never both strobed (R7)
  assert_no_drive_on_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrLane != '0) |-> (strobes.driveLane == '0));
endmodule

// File: rtl/sram_x16x8.sv
module sram_x16x8
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DEPTH_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordMode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byteAddr,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              oeN,
  input  logic              weN,
  input  logic              lbN,
  input  logic              ubN,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic [1:0]        laneOe
);
  strobes_t strobes;

  sram_ctrl #(.ADDR_W(ADDR_W), .DEPTH_W(DEPTH_W)) uCtrl (
    .wordMode(wordMode), .addr(addr), .byteAddr(byteAddr),
    .ce1N(ce1N), .ce2(ce2), .oeN(oeN), .weN(weN),
    .lbN(lbN), .ubN(ubN), .strobes(strobes)
  );

  sram_datapath #(.DEPTH_W(DEPTH_W)) uData (
    .clk(clk), .rstN(rstN), .wordIdx(addr[DEPTH_W-1:0]),
    .dataIn(dataIn), .strobes(strobes),
    .dataOut(dataOut), .laneOe(laneOe)
  );

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ce1N || !ce2) |=> (laneOe == 2'b00));

  assert_byte_upper_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    !wordMode |=> (!laneOe[1] && dataOut[15:8] == 8'h00));

  assert_both_masked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wordMode && lbN && ubN) |=> (laneOe == 2'b00));

  assert_oe_high_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    oeN |=> (laneOe == 2'b00));

  assert_write_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !weN |=> (laneOe == 2'b00));

  assert_undriven_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (laneOe == 2'b00) |-> (dataOut == 16'h0000));
endmodule

// File: tb/sim_sram_x16x8.sv
`timescale 1ns/1ps
module sim_sram_x16x8;
  localparam int DEPTH_W = 10;
  localparam int DEPTH   = 1 << DEPTH_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordMode = 1'b1;
  logic [16:0] addr = '0;
  logic        byteAddr = 1'b0;
  logic        ce1N = 1'b1, ce2 = 1'b0, oeN = 1'b1, weN = 1'b1, lbN = 1'b1, ubN = 1'b1;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic [1:0]  laneOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] refMem [int];
  logic [15:0] expData = '0;
  logic [1:0]  expOe = '0;
  string       lastTag = "R11";

  always #4 clk = ~clk;

  sram_x16x8 #(.ADDR_W(17), .DEPTH_W(DEPTH_W)) u0 (
    .clk(clk), .rstN(rstN), .wordMode(wordMode), .addr(addr), .byteAddr(byteAddr),
    .ce1N(ce1N), .ce2(ce2), .oeN(oeN), .weN(weN), .lbN(lbN), .ubN(ubN),
    .dataIn(dataIn), .dataOut(dataOut), .laneOe(laneOe)
  );

  task automatic compare();
    checks++;
    if (dataOut !== expData || laneOe !== expOe) begin
      errors++;
      $display("FAIL %s: dataOut=%h laneOe=%b expected dataOut=%h laneOe=%b",
               lastTag, dataOut, laneOe, expData, expOe);
    end
  endtask

  // One cycle: check outputs of the previous cycle, drive new inputs, update model
  task automatic step(string tag, bit wm, int a, bit ba, bit c1n, bit c2, bit oen,
                      bit wen, bit lbn, bit ubn, logic [15:0] din);
    bit sel, wr, rd;
    int idx;
    logic [15:0] old;
    @(negedge clk);
    compare();
    wordMode = wm; addr = 17'(a); byteAddr = ba; ce1N = c1n; ce2 = c2;
    oeN = oen; weN = wen; lbN = lbn; ubN = ubn; dataIn = din;
    sel = !c1n && c2 && (a < DEPTH) && (!wm || !(lbn && ubn));
    wr = sel && !wen;
    rd = sel && wen && !oen;
    idx = a % DEPTH;
    old = refMem.exists(idx) ? refMem[idx] : 16'h0000;
    expOe = 2'b00; expData = 16'h0000;
    if (rd) begin
      if (wm) begin
        expOe = {!ubn, !lbn};
        expData = {ubn ? 8'h00 : old[15:8], lbn ? 8'h00 : old[7:0]};
      end else begin
        expOe = 2'b01;
        expData = {8'h00, ba ? old[15:8] : old[7:0]};
      end
    end
    if (wr) begin
      if (wm) refMem[idx] = {ubn ? old[15:8] : din[15:8], lbn ? old[7:0] : din[7:0]};
      else if (ba) refMem[idx] = {din[7:0], old[7:0]};
      else refMem[idx] = {old[15:8], din[7:0]};
    end
    lastTag = tag;
  endtask

  task automatic wrW(string tag, int a, logic [15:0] d);
    step(tag, 1, a, 0, 0, 1, 1, 0, 0, 0, d);
  endtask
  task automatic rdW(string tag, int a);
    step(tag, 1, a, 0, 0, 1, 0, 1, 0, 0, 16'h0);
  endtask
  task automatic wrB(string tag, int a, bit ba, logic [7:0] d);
    step(tag, 0, a, ba, 0, 1, 1, 0, 1, 1, {8'hEE, d});
  endtask
  task automatic rdB(string tag, int a, bit ba);
    step(tag, 0, a, ba, 0, 1, 0, 1, 1, 1, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state compared on the first step
    step("R11", 1, 0, 0, 1, 0, 1, 1, 1, 1, 16'h0);
    for (int i = 0; i < 8; i++) wrW("R2", i, 16'(16'h1100 * i + 16'h0A5 + i));
    for (int i = 0; i < 8; i++) rdW("R10", i);
    // R2: byteAddr ignored in word mode
    step("R2", 1, 3, 1, 0, 1, 0, 1, 0, 0, 16'h0);
    step("R2", 1, 4, 1, 0, 1, 1, 0, 0, 0, 16'hBEEF);
    rdW("R2", 4);
    // R9: word written, read as bytes
    wrW("R9", 5, 16'hC3A4);
    rdB("R9", 5, 0);
    rdB("R9", 5, 1);
    // R9: bytes written, read as word
    wrB("R3", 6, 0, 8'h5A);
    wrB("R3", 6, 1, 8'h96);
    rdW("R9", 6);
    // R8: lane enables don't care in byte mode
    step("R8", 0, 2, 1, 0, 1, 0, 1, 0, 0, 16'h0);
    step("R8", 0, 2, 0, 0, 1, 0, 1, 0, 1, 16'h0);
    step("R8", 0, 7, 1, 0, 1, 1, 0, 0, 0, 16'h0071);
    rdW("R8", 7);
    // R6: lane masks on write and read
    step("R6", 1, 1, 0, 0, 1, 1, 0, 0, 1, 16'h7788);
    rdW("R6", 1);
    step("R6", 1, 1, 0, 0, 1, 1, 0, 1, 0, 16'h99AA);
    rdW("R6", 1);
    step("R6", 1, 1, 0, 0, 1, 0, 1, 0, 1, 16'h0);
    step("R6", 1, 1, 0, 0, 1, 0, 1, 1, 0, 16'h0);
    // R1: deselected writes ignored
    step("R1", 1, 0, 0, 1, 1, 0, 0, 0, 0, 16'hDEAD);
    step("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0, 16'hDEAD);
    step("R1", 1, 0, 0, 1, 0, 0, 1, 0, 0, 16'h0);
    rdW("R1", 0);
    // R4: both lanes masked
    step("R4", 1, 0, 0, 0, 1, 1, 0, 1, 1, 16'hFACE);
    step("R4", 1, 0, 0, 0, 1, 0, 1, 1, 1, 16'h0);
    rdW("R4", 0);
    // R5: output enable high gives no drive
    step("R5", 1, 2, 0, 0, 1, 1, 1, 0, 0, 16'h0);
    step("R5", 0, 2, 0, 0, 1, 1, 1, 0, 0, 16'h0);
    rdW("R5", 2);
    // R7: write with oeN low still writes, no drive
    step("R7", 1, 3, 0, 0, 1, 0, 0, 0, 0, 16'h4242);
    rdW("R7", 3);
    step("R7", 0, 3, 1, 0, 1, 0, 0, 1, 1, 16'h0013);
    rdW("R7", 3);
    // R12: out-of-range address acts deselected
    step("R12", 1, DEPTH + 3, 0, 0, 1, 1, 0, 0, 0, 16'h0BAD);
    step("R12", 1, DEPTH + 3, 0, 0, 1, 0, 1, 0, 0, 16'h0);
    rdW("R12", 3);
    // R10: back-to-back write then read
    for (int i = 0; i < 4; i++) begin
      wrW("R10", i, 16'(16'h2468 ^ (i * 16'h1357)));
      rdW("R10", i);
    end
    step("R10", 1, 0, 0, 1, 0, 1, 1, 1, 1, 16'h0);
    step("R10", 1, 0, 0, 1, 0, 1, 1, 1, 1, 16'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule